// File: doc/BRIEF.md
# Host/DSP Command and Reply Mailbox

The block carries short messages between a host processor and a DSP over three independent 16-bit channels. On each channel the host posts a command word that the DSP later fetches, and the DSP posts a reply word that the host later collects. Two handshake flags per channel show where each exchange stands. Both flags are active-low: a 0 means the DSP has taken the command, or the DSP has left a reply that has not been read yet.

The host reaches the block through a byte-offset register window with separate read and write strobes. The read data is combinational from the current state. The DSP selects a channel by index and uses its own read and write strobes. A read strobe on either side is a consuming access that updates a handshake flag. One interrupt line, gated per channel by enable bits in a configuration word, tells the host that an enabled channel holds a fresh reply.

Top module: `cmd_reply_mailbox`

## Requirements
- R1: After reset the status word at offset 0x0C reads 0xFC00 (all six handshake flags at 1), every command and reply register reads 0, the configuration word reads 0 and irq_o is 0.
- R2: A host write to offset 0x20, 0x28 or 0x30 stores the word for channel 0, 1 or 2. On the DSP side it reads as dsp_rdata_o while dsp_ch_i selects that channel, and it sets that channel's command flag (status bit 13, 14 or 15) to 1.
- R3: A DSP read strobe (dsp_re_i) on channel n clears status bit 13+n to 0 and leaves the command data unchanged.
- R4: A DSP write strobe (dsp_we_i) on channel n stores dsp_wdata_i as the reply, readable by the host at offset 0x24, 0x2C or 0x34, and clears status bit 10+n to 0.
- R5: A host read strobe (host_re_i) at a reply offset returns the reply and sets status bit 10+n back to 1 on the next edge.
- R6: When a host command write and a DSP read of the same channel happen in one cycle, the new word is stored and the command flag ends at 1.
- R7: When a DSP reply write and a host reply read of the same channel happen in one cycle, the new reply is stored and the reply flag ends at 0.
- R8: Configuration offset 0x08 holds reply interrupt enables in bits 9, 10 and 11 for channels 0, 1 and 2; its other bits read 0. irq_o is 1 exactly when some channel has its enable set and its reply flag at 0.
- R9: DSP channel index 3 selects nothing: its strobes change no flag and no data, and dsp_rdata_o reads 0.
- R10: Host writes to the status offset or to unmapped offsets change nothing, host reads of unmapped offsets return 0, and status bits 0 to 9 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 8 | Host byte offset |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host consuming read strobe |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data (combinational) |
| dsp_ch_i | input | 2 | DSP channel select |
| dsp_we_i | input | 1 | DSP reply write strobe |
| dsp_re_i | input | 1 | DSP command read strobe |
| dsp_wdata_i | input | 16 | DSP reply data |
| dsp_rdata_o | output | 16 | Command word of the selected channel |
| irq_o | output | 1 | Reply interrupt to the host |

## Verification
Assertions check four things on every cycle: each strobe drives its flag to the required level on the next edge, command and reply words hold when no write targets them, an enabled reply write raises irq_o, and an invalid DSP channel reads 0. Other behaviour only shows in the bench scenarios: the exact status and configuration bit layout, priority when both sides act on one channel in the same cycle, writes to read-only or unmapped offsets being ignored, and the reset values seen again after a mid-run reset.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DW       = 16;
  localparam int AW       = 8;
  localparam int NCH      = 3;
  localparam int CHW      = $clog2(NCH + 1);
  localparam int CFG_OFS  = 'h08;
  localparam int STS_OFS  = 'h0C;
  localparam int CMD_BASE = 'h20;
  localparam int REP_OFS  = 'h04;
  localparam int CH_STEP  = 'h08;
  // bit positions decoded by host software
  localparam int IEN_LSB  = 9;
  localparam int REPF_LSB = 10;
  localparam int CMDF_LSB = 13;

  typedef logic [DW-1:0] word_t;
endpackage

// File: rtl/mbox_channel.sv
module mbox_channel
  import mbox_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  host_cmd_we_i,
  input  logic  host_rep_re_i,
  input  word_t host_wdata_i,
  input  logic  dsp_cmd_re_i,
  input  logic  dsp_rep_we_i,
  input  word_t dsp_wdata_i,
  output word_t cmd_q_o,
  output word_t rep_q_o,
  output logic  cmd_rd_n_o,
  output logic  rep_new_n_o
);
  word_t cmd_q, rep_q;
  logic  cmd_rd_n, rep_new_n;

  // command side: host write outranks DSP consume
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      cmd_rd_n <= 1'b1;
    end else if (host_cmd_we_i) begin
      cmd_q    <= host_wdata_i;
      cmd_rd_n <= 1'b1;
    end else if (dsp_cmd_re_i) begin
      cmd_rd_n <= 1'b0;
    end
  end

  // reply side: DSP post outranks host consume
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q     <= '0;
      rep_new_n <= 1'b1;
    end else if (dsp_rep_we_i) begin
      rep_q     <= dsp_wdata_i;
      rep_new_n <= 1'b0;
    end else if (host_rep_re_i) begin
      rep_new_n <= 1'b1;
    end
  end

  assign cmd_q_o     = cmd_q;
  assign rep_q_o     = rep_q;
  assign cmd_rd_n_o  = cmd_rd_n;
  assign rep_new_n_o = rep_new_n;

  p_cmd_post_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_cmd_we_i |=> cmd_rd_n_o && (cmd_q_o == $past(host_wdata_i)));
  p_cmd_take_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsp_cmd_re_i && !host_cmd_we_i) |=> !cmd_rd_n_o);
  p_cmd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_cmd_we_i |=> $stable(cmd_q_o));
  p_rep_post_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsp_rep_we_i |=> !rep_new_n_o && (rep_q_o == $past(dsp_wdata_i)));
  p_rep_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rep_re_i && !dsp_rep_we_i) |=> rep_new_n_o);
  p_rep_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dsp_rep_we_i |=> $stable(rep_q_o));
endmodule

// File: rtl/mbox_host_regs.sv
module mbox_host_regs
  import mbox_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           addr_i,
  input  logic                    we_i,
  input  logic                    re_i,
  input  word_t                   wdata_i,
  input  logic [NCH-1:0][DW-1:0]  cmd_q_i,
  input  logic [NCH-1:0][DW-1:0]  rep_q_i,
  input  logic [NCH-1:0]          cmd_rd_n_i,
  input  logic [NCH-1:0]          rep_new_n_i,
  output logic [NCH-1:0]          cmd_we_o,
  output logic [NCH-1:0]          rep_re_o,
  output logic [NCH-1:0]          ien_o,
  output word_t                   rdata_o
);
  logic [NCH-1:0] ien_q;
  logic [NCH-1:0] hit_cmd, hit_rep;
  logic           hit_cfg, hit_sts;
  word_t          sts_w, cfg_w;

  assign hit_cfg = (addr_i == AW'(CFG_OFS));
  assign hit_sts = (addr_i == AW'(STS_OFS));

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    assign hit_cmd[n]  = (addr_i == AW'(CMD_BASE + n * CH_STEP));
    assign hit_rep[n]  = (addr_i == AW'(CMD_BASE + n * CH_STEP + REP_OFS));
    assign cmd_we_o[n] = we_i & hit_cmd[n];
    assign rep_re_o[n] = re_i & hit_rep[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ien_q <= '0;
    else if (we_i && hit_cfg) ien_q <= wdata_i[IEN_LSB +: NCH];
  end
  assign ien_o = ien_q;

  always_comb begin
    sts_w = '0;
    sts_w[REPF_LSB +: NCH] = rep_new_n_i;
    sts_w[CMDF_LSB +: NCH] = cmd_rd_n_i;
    cfg_w = '0;
    cfg_w[IEN_LSB +: NCH]  = ien_q;
  end

  always_comb begin
    rdata_o = '0;
    if (hit_cfg) rdata_o = cfg_w;
    if (hit_sts) rdata_o = sts_w;
    for (int n = 0; n < NCH; n++) begin
      if (hit_cmd[n]) rdata_o = cmd_q_i[n];
      if (hit_rep[n]) rdata_o = rep_q_i[n];
    end
  end

  p_ien_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && hit_cfg) |=> $stable(ien_o));
  p_one_target_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_cmd, hit_rep, hit_cfg, hit_sts}));
endmodule

// File: rtl/cmd_reply_mailbox.sv
module cmd_reply_mailbox
  import mbox_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] host_addr_i,
  input  logic          host_we_i,
  input  logic          host_re_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic [CHW-1:0] dsp_ch_i,
  input  logic          dsp_we_i,
  input  logic          dsp_re_i,
  input  logic [DW-1:0] dsp_wdata_i,
  output logic [DW-1:0] dsp_rdata_o,
  output logic          irq_o
);
  logic [NCH-1:0][DW-1:0] cmd_q, rep_q;
  logic [NCH-1:0]         cmd_rd_n, rep_new_n;
  logic [NCH-1:0]         cmd_we, rep_re, ien, dsp_sel;

  mbox_host_regs u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (host_addr_i),
    .we_i        (host_we_i),
    .re_i        (host_re_i),
    .wdata_i     (host_wdata_i),
    .cmd_q_i     (cmd_q),
    .rep_q_i     (rep_q),
    .cmd_rd_n_i  (cmd_rd_n),
    .rep_new_n_i (rep_new_n),
    .cmd_we_o    (cmd_we),
    .rep_re_o    (rep_re),
    .ien_o       (ien),
    .rdata_o     (host_rdata_o)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign dsp_sel[n] = (dsp_ch_i == CHW'(n));
    mbox_channel u_ch (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .host_cmd_we_i (cmd_we[n]),
      .host_rep_re_i (rep_re[n]),
      .host_wdata_i  (host_wdata_i),
      .dsp_cmd_re_i  (dsp_re_i & dsp_sel[n]),
      .dsp_rep_we_i  (dsp_we_i & dsp_sel[n]),
      .dsp_wdata_i   (dsp_wdata_i),
      .cmd_q_o       (cmd_q[n]),
      .rep_q_o       (rep_q[n]),
      .cmd_rd_n_o    (cmd_rd_n[n]),
      .rep_new_n_o   (rep_new_n[n])
    );
  end

  always_comb begin
    dsp_rdata_o = '0;
    for (int n = 0; n < NCH; n++)
      if (dsp_sel[n]) dsp_rdata_o = cmd_q[n];
  end

  assign irq_o = |(ien & ~rep_new_n);

  p_irq_on_reply_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsp_we_i && |(dsp_sel & ien) && !host_we_i) |=> irq_o);
  p_bad_ch_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsp_sel == '0) |-> (dsp_rdata_o == '0));
endmodule

// File: tb/cmd_reply_mailbox_tb.sv
module cmd_reply_mailbox_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  h_addr = '0;
  logic        h_we = 1'b0, h_re = 1'b0;
  logic [15:0] h_wd = '0;
  logic [15:0] h_rd;
  logic [1:0]  d_ch = '0;
  logic        d_we = 1'b0, d_re = 1'b0;
  logic [15:0] d_wd = '0;
  logic [15:0] d_rd;
  logic        irq;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk; // 250 MHz

  cmd_reply_mailbox dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_addr_i(h_addr), .host_we_i(h_we), .host_re_i(h_re),
    .host_wdata_i(h_wd), .host_rdata_o(h_rd),
    .dsp_ch_i(d_ch), .dsp_we_i(d_we), .dsp_re_i(d_re),
    .dsp_wdata_i(d_wd), .dsp_rdata_o(d_rd), .irq_o(irq)
  );

  // ops: 0 host write, 1 host consuming read, 2 DSP write, 3 DSP read, 4 host peek
  localparam int NV = 22;
  localparam logic [46:0] VEC [NV] = '{
    {4'd1, 3'd4, 8'h0C, 16'h0000, 16'hFC00}, // R1 status
    {4'd1, 3'd4, 8'h24, 16'h0000, 16'h0000}, // R1 reply 0
    {4'd2, 3'd0, 8'h20, 16'hA5A5, 16'h0000},
    {4'd2, 3'd3, 8'h00, 16'h0000, 16'hA5A5}, // R2 DSP sees command
    {4'd3, 3'd4, 8'h0C, 16'h0000, 16'hDC00}, // R3 bit13 low
    {4'd3, 3'd4, 8'h20, 16'h0000, 16'hA5A5}, // R3 data kept
    {4'd2, 3'd0, 8'h20, 16'h1234, 16'h0000},
    {4'd2, 3'd4, 8'h0C, 16'h0000, 16'hFC00}, // R2 flag back to 1
    {4'd4, 3'd2, 8'h01, 16'hBEEF, 16'h0000},
    {4'd4, 3'd4, 8'h0C, 16'h0000, 16'hF400}, // R4 bit11 low
    {4'd5, 3'd1, 8'h2C, 16'h0000, 16'hBEEF}, // R5 read returns reply
    {4'd5, 3'd4, 8'h0C, 16'h0000, 16'hFC00}, // R5 flag restored
    {4'd2, 3'd0, 8'h28, 16'h0001, 16'h0000},
    {4'd2, 3'd3, 8'h01, 16'h0000, 16'h0001}, // R2 channel 1
    {4'd2, 3'd0, 8'h30, 16'h7777, 16'h0000},
    {4'd2, 3'd3, 8'h02, 16'h0000, 16'h7777}, // R2 channel 2
    {4'd3, 3'd4, 8'h0C, 16'h0000, 16'h3C00}, // R3 bits 14,15 low
    {4'd4, 3'd2, 8'h02, 16'h00FF, 16'h0000},
    {4'd4, 3'd4, 8'h0C, 16'h0000, 16'h2C00}, // R4 bit12 low
    {4'd5, 3'd1, 8'h34, 16'h0000, 16'h00FF}, // R5
    {4'd5, 3'd4, 8'h0C, 16'h0000, 16'h3C00}, // R5
    {4'd2, 3'd4, 8'h28, 16'h0000, 16'h0001}  // R2 host view of command
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    h_we = 1'b0; h_re = 1'b0; d_we = 1'b0; d_re = 1'b0;
  endtask

  task automatic hw(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); h_addr = a; h_wd = d; h_we = 1'b1; idle();
  endtask

  task automatic hpeek(input string tag, input logic [7:0] a, input logic [15:0] e);
    @(negedge clk); h_addr = a; #1 chk(tag, h_rd, e);
  endtask

  task automatic dw(input logic [1:0] c, input logic [15:0] d);
    @(negedge clk); d_ch = c; d_wd = d; d_we = 1'b1; idle();
  endtask

  task automatic irq_chk(input string tag, input logic e);
    @(negedge clk); #1 chk(tag, {15'd0, irq}, {15'd0, e});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 irq", {15'd0, irq}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  rq;
      logic [2:0]  op;
      logic [7:0]  ad;
      logic [15:0] dv, ev;
      {rq, op, ad, dv, ev} = VEC[i];
      @(negedge clk);
      case (op)
        3'd0: begin h_addr = ad; h_wd = dv; h_we = 1'b1; end
        3'd1: begin h_addr = ad; h_re = 1'b1; #1 chk($sformatf("R%0d vec%0d", rq, i), h_rd, ev); end
        3'd2: begin d_ch = ad[1:0]; d_wd = dv; d_we = 1'b1; end
        3'd3: begin d_ch = ad[1:0]; d_re = 1'b1; #1 chk($sformatf("R%0d vec%0d", rq, i), d_rd, ev); end
        default: begin h_addr = ad; #1 chk($sformatf("R%0d vec%0d", rq, i), h_rd, ev); end
      endcase
      idle();
    end

    // R6: host command write and DSP read of channel 0 together
    @(negedge clk);
    h_addr = 8'h20; h_wd = 16'h6666; h_we = 1'b1; d_ch = 2'd0; d_re = 1'b1;
    idle();
    hpeek("R6 flag", 8'h0C, 16'h3C00);
    hpeek("R6 data", 8'h20, 16'h6666);

    // R7: DSP reply write and host reply read of channel 1 together
    dw(2'd1, 16'h1111);
    @(negedge clk);
    h_addr = 8'h2C; h_re = 1'b1; d_ch = 2'd1; d_wd = 16'h2222; d_we = 1'b1;
    idle();
    hpeek("R7 flag", 8'h0C, 16'h3400);
    hpeek("R7 data", 8'h2C, 16'h2222);
    @(negedge clk); h_addr = 8'h2C; h_re = 1'b1; idle();
    hpeek("R7 cleared", 8'h0C, 16'h3C00);

    // R8: enables and interrupt
    hw(8'h08, 16'hFFFF);
    hpeek("R8 cfg readback", 8'h08, 16'h0E00);
    irq_chk("R8 no reply", 1'b0);
    dw(2'd0, 16'h0A0A);
    irq_chk("R8 ch0 reply", 1'b1);
    hw(8'h08, 16'h0C00);
    irq_chk("R8 ch0 masked", 1'b0);
    dw(2'd2, 16'h0C0C);
    irq_chk("R8 ch2 reply", 1'b1);
    @(negedge clk); h_addr = 8'h34; h_re = 1'b1; idle();
    irq_chk("R8 ch2 read", 1'b0);
    hw(8'h08, 16'h0200);
    irq_chk("R8 ch0 unmasked", 1'b1);
    @(negedge clk); h_addr = 8'h24; h_re = 1'b1; idle();
    irq_chk("R8 ch0 read", 1'b0);

    // R9: channel index 3 does nothing
    @(negedge clk); d_ch = 2'd3; #1 chk("R9 rdata", d_rd, 16'h0000);
    d_we = 1'b1; d_re = 1'b1; d_wd = 16'hDEAD; idle();
    hpeek("R9 status", 8'h0C, 16'h3C00);
    hpeek("R9 reply0", 8'h24, 16'h0A0A);
    hpeek("R9 reply2", 8'h34, 16'h0C0C);

    // R10: read-only and unmapped offsets
    hw(8'h0C, 16'hFFFF);
    hpeek("R10 status write", 8'h0C, 16'h3C00);
    hw(8'h40, 16'hFFFF);
    hpeek("R10 unmapped read", 8'h40, 16'h0000);
    hpeek("R10 unmapped 0x22", 8'h22, 16'h0000);
    hpeek("R10 cmd0 intact", 8'h20, 16'h6666);
    hpeek("R10 cfg intact", 8'h08, 16'h0200);

    // R1: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    #1;
    h_addr = 8'h0C; #1 chk("R1 rst status", h_rd, 16'hFC00);
    h_addr = 8'h20; #1 chk("R1 rst cmd0", h_rd, 16'h0000);
    h_addr = 8'h08; #1 chk("R1 rst cfg", h_rd, 16'h0000);
    chk("R1 rst irq", {15'd0, irq}, 16'd0);
    @(negedge clk); rst_n = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule